// File: doc/BRIEF.md
# Block-Transfer Address Sequencer

This unit turns a single multi-register memory transfer request into a run of word accesses. A request carries a base address, a 16-bit register mask, a 2-bit addressing mode, a writeback enable and a load/store direction. For every set bit of the mask the unit issues one beat carrying that register's index and its word address. It walks the registers from the lowest index upward and the addresses from low to high, so the lowest-numbered register always lands on the lowest address, whichever mode is chosen.

Beats leave through a valid/ready handshake. They run back to back whenever the consumer stays ready. When the last beat has been taken, the unit raises a one-cycle completion pulse. In that same cycle it presents the updated base address that a register file may write back. The direction bit rides along with every beat untouched. The mask's population count alone sets both the starting address and the writeback value.

Top module: `blk_xfer_seq`

## Requirements
- R1: `start_i` is taken only while `busy_o` is low. `busy_o` then stays high from the next cycle until the cycle after the done pulse. A `start_i` seen while busy changes no beat, address or writeback value.
- R2: Exactly one beat is issued per set bit of the mask. Mask bit k is the register with index k, and beats come out in strictly ascending index order on `beat_reg_o`.
- R3: The mode encoding is 0 = step up, address taken before stepping; 1 = step up, step before the first address; 2 = step down, ending at the base; 3 = step down, ending one word below the base. With n set bits and aligned base B, the first beat address is B, B+4, B-4n+4 and B-4n for modes 0, 1, 2 and 3 respectively.
- R4: Each beat after the first is 4 above the previous beat's address.
- R5: The aligned base is the base with bits 1:0 cleared. Every issued address has bits 1:0 equal to zero.
- R6: While `beat_valid_o` is high and `beat_ready_i` is low, the beat stays valid and its address and register index hold.
- R7: `done_o` is high for exactly one cycle. That cycle immediately follows the handshake of the last beat, and no beat is valid in it.
- R8: In the done cycle, `wb_addr_o` is B+4n for modes 0 and 1 and B-4n for modes 2 and 3. `wb_valid_o` is high only in the done cycle, and only when the request's writeback enable was set.
- R9: An empty mask issues no beat. It raises `done_o` in the cycle right after acceptance and returns the aligned base unchanged as `wb_addr_o`.
- R10: `beat_load_o` carries, on every beat, the `dir_load_i` value that was captured at acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Request strobe, taken when idle |
| base_i | input | 32 | Base address of the request |
| reg_list_i | input | 16 | Register mask, bit k = register k |
| mode_i | input | 2 | Addressing mode (see R3) |
| wb_en_i | input | 1 | Request base writeback |
| dir_load_i | input | 1 | Direction, 1 = load, passed through |
| busy_o | output | 1 | A request is in progress |
| beat_valid_o | output | 1 | Beat offered |
| beat_ready_i | input | 1 | Consumer takes the beat |
| beat_addr_o | output | 32 | Word address of the beat |
| beat_reg_o | output | 4 | Register index of the beat |
| beat_load_o | output | 1 | Direction of the beat |
| done_o | output | 1 | One-cycle completion pulse |
| wb_valid_o | output | 1 | Writeback value is to be used |
| wb_addr_o | output | 32 | Updated base for writeback |

## Verification
The properties check, on every cycle, the invariants that relate neighbouring cycles. These are: a stalled beat holds, addresses step by one word, register indices climb, addresses stay aligned, done is a lone pulse with no beat beside it, writeback is offered only at done, and busy covers every beat. What no cycle-local property can show is that the whole run is correct. That covers the right first address for each mode and count, the exact number of beats, the writeback value, the empty-mask path and a start ignored mid-run. The bench's per-request scenarios, which compare against values worked out from the requirements, cover these.

// File: rtl/blk_xfer_pkg.sv
// Shared types for the block-transfer address sequencer.
// Assumes a 2-bit mode field: bit 1 selects downward stepping and bit 0
// selects the "step first" variant.
package blk_xfer_pkg;

    typedef enum logic [1:0] {
        MODE_UP_POST   = 2'b00,
        MODE_UP_PRE    = 2'b01,
        MODE_DOWN_POST = 2'b10,
        MODE_DOWN_PRE  = 2'b11
    } xfer_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'b00,
        ST_RUN  = 2'b01,
        ST_FIN  = 2'b10
    } seq_state_e;

endpackage

// File: rtl/xfer_popcnt.sv
// Population count of the register mask.
// Purely combinational; the count is wide enough to hold W.
module xfer_popcnt #(
    parameter int W    = 16,
    parameter int CW   = $clog2(W + 1)
) (
    input  logic [W-1:0]  bits_i,
    output logic [CW-1:0] count_o
);

    // Sum the set bits of the mask.
    always_comb begin
        count_o = '0;
        for (int i = 0; i < W; i++) begin
            count_o = count_o + CW'(bits_i[i]);
        end
    end

endmodule

// File: rtl/xfer_lsb_pick.sv
// Finds the lowest set bit of a pending mask and reports its index.
// Assumes the caller ignores idx_o when any_o is low.
module xfer_lsb_pick #(
    parameter int W  = 16,
    parameter int IW = $clog2(W)
) (
    input  logic [W-1:0]  bits_i,
    output logic [IW-1:0] idx_o,
    output logic          any_o
);

    // Scan from the top so that the lowest set bit wins last.
    always_comb begin
        idx_o = '0;
        for (int i = W - 1; i >= 0; i--) begin
            if (bits_i[i]) idx_o = IW'(i);
        end
        any_o = |bits_i;
    end

endmodule

// File: rtl/xfer_addr_plan.sv
// Computes the first beat address and the writeback address of a request
// from the base, the number of set mask bits and the addressing mode.
// Assumes word size 2**STEP_SH bytes; the base is aligned down first.
module xfer_addr_plan
    import blk_xfer_pkg::*;
#(
    parameter int AW      = 32,
    parameter int CW      = 5,
    parameter int STEP_SH = 2
) (
    input  logic [AW-1:0] base_i,
    input  logic [CW-1:0] count_i,
    input  xfer_mode_e    mode_i,
    output logic [AW-1:0] first_o,
    output logic [AW-1:0] final_o
);

    localparam logic [AW-1:0] STEP     = AW'(1) << STEP_SH;
    localparam logic [AW-1:0] LOW_MASK = STEP - AW'(1);

    logic [AW-1:0] aligned;
    logic [AW-1:0] span;

    // Align the base and scale the count to a byte span.
    always_comb begin
        aligned = base_i & ~LOW_MASK;
        span    = AW'(count_i) << STEP_SH;
    end

    // Select the start and end points per mode.
    always_comb begin
        unique case (mode_i)
            MODE_UP_POST: begin
                first_o = aligned;
                final_o = aligned + span;
            end
            MODE_UP_PRE: begin
                first_o = aligned + STEP;
                final_o = aligned + span;
            end
            MODE_DOWN_POST: begin
                first_o = aligned - span + STEP;
                final_o = aligned - span;
            end
            default: begin
                first_o = aligned - span;
                final_o = aligned - span;
            end
        endcase
    end

endmodule

// File: rtl/blk_xfer_seq.sv
// Block-transfer address sequencer: accepts a request while idle, issues one
// valid/ready beat per set mask bit in ascending register order with
// ascending word addresses, then pulses done with the writeback base.
// Assumes the consumer samples beats on the clock edge where ready is high.
module blk_xfer_seq
    import blk_xfer_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int LIST_W  = 16,
    parameter int STEP_SH = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      start_i,
    input  logic [ADDR_W-1:0]         base_i,
    input  logic [LIST_W-1:0]         reg_list_i,
    input  logic [1:0]                mode_i,
    input  logic                      wb_en_i,
    input  logic                      dir_load_i,
    output logic                      busy_o,
    output logic                      beat_valid_o,
    input  logic                      beat_ready_i,
    output logic [ADDR_W-1:0]         beat_addr_o,
    output logic [$clog2(LIST_W)-1:0] beat_reg_o,
    output logic                      beat_load_o,
    output logic                      done_o,
    output logic                      wb_valid_o,
    output logic [ADDR_W-1:0]         wb_addr_o
);

    localparam int IDX_W = $clog2(LIST_W);
    localparam int CNT_W = $clog2(LIST_W + 1);
    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(1) << STEP_SH;

    seq_state_e          state_q;
    logic [LIST_W-1:0]   pend_q;
    logic [LIST_W-1:0]   pend_next;
    logic [ADDR_W-1:0]   addr_q;
    logic [ADDR_W-1:0]   fin_q;
    logic                load_q;
    logic                wb_q;
    logic [CNT_W-1:0]    n_set;
    logic [ADDR_W-1:0]   first_c;
    logic [ADDR_W-1:0]   final_c;
    logic [IDX_W-1:0]    idx_c;
    logic                any_c;
    logic                accept;
    logic                hs;

    xfer_popcnt #(.W(LIST_W), .CW(CNT_W)) u_cnt (
        .bits_i  (reg_list_i),
        .count_o (n_set)
    );

    xfer_addr_plan #(.AW(ADDR_W), .CW(CNT_W), .STEP_SH(STEP_SH)) u_plan (
        .base_i  (base_i),
        .count_i (n_set),
        .mode_i  (xfer_mode_e'(mode_i)),
        .first_o (first_c),
        .final_o (final_c)
    );

    xfer_lsb_pick #(.W(LIST_W), .IW(IDX_W)) u_pick (
        .bits_i (pend_q),
        .idx_o  (idx_c),
        .any_o  (any_c)
    );

    // Decode acceptance, handshake and the mask left after this beat.
    always_comb begin
        accept    = start_i && (state_q == ST_IDLE);
        hs        = beat_valid_o && beat_ready_i;
        pend_next = pend_q & ~(LIST_W'(1) << idx_c);
    end

    // Sequencer state, pending mask and address registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            pend_q  <= '0;
            addr_q  <= '0;
            fin_q   <= '0;
            load_q  <= 1'b0;
            wb_q    <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (accept) begin
                        pend_q  <= reg_list_i;
                        addr_q  <= first_c;
                        fin_q   <= final_c;
                        load_q  <= dir_load_i;
                        wb_q    <= wb_en_i;
                        state_q <= (|reg_list_i) ? ST_RUN : ST_FIN;
                    end
                end
                ST_RUN: begin
                    if (hs) begin
                        pend_q <= pend_next;
                        addr_q <= addr_q + STEP;
                        if (pend_next == '0) state_q <= ST_FIN;
                    end
                end
                default: begin
                    state_q <= ST_IDLE;
                end
            endcase
        end
    end

    // Drive the outputs from the registered state.
    always_comb begin
        busy_o       = (state_q != ST_IDLE);
        beat_valid_o = (state_q == ST_RUN) && any_c;
        beat_addr_o  = addr_q;
        beat_reg_o   = idx_c;
        beat_load_o  = load_q;
        done_o       = (state_q == ST_FIN);
        wb_valid_o   = done_o && wb_q;
        wb_addr_o    = fin_q;
    end

endmodule

// File: rtl/blk_xfer_seq_chk.sv
// Property checker for blk_xfer_seq, bound to every instance of it.
// Assumes the synchronous active-low reset is held for at least one edge.
module blk_xfer_seq_chk #(
    parameter int ADDR_W  = 32,
    parameter int LIST_W  = 16,
    parameter int STEP_SH = 2
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      start_i,
    input logic                      busy_o,
    input logic                      beat_valid_o,
    input logic                      beat_ready_i,
    input logic [ADDR_W-1:0]         beat_addr_o,
    input logic [$clog2(LIST_W)-1:0] beat_reg_o,
    input logic                      done_o,
    input logic                      wb_valid_o
);

    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(1) << STEP_SH;

    // R1
    start_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_i && !busy_o |=> busy_o);

    // R1
    beat_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        beat_valid_o |-> busy_o);

    // R2
    reg_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        beat_valid_o && beat_ready_i |=> !beat_valid_o || (beat_reg_o > $past(beat_reg_o)));

    // R4
    addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        beat_valid_o && beat_ready_i |=> !beat_valid_o || (beat_addr_o == $past(beat_addr_o) + STEP));

    // R5
    addr_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        beat_valid_o |-> (beat_addr_o[STEP_SH-1:0] == '0));

    // R6
    beat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        beat_valid_o && !beat_ready_i |=> beat_valid_o && $stable(beat_addr_o) && $stable(beat_reg_o));

    // R7
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R7
    done_alone_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !beat_valid_o);

    // R8
    wb_at_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid_o |-> done_o);

endmodule

bind blk_xfer_seq blk_xfer_seq_chk #(
    .ADDR_W  (ADDR_W),
    .LIST_W  (LIST_W),
    .STEP_SH (STEP_SH)
) i_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_i),
    .busy_o       (busy_o),
    .beat_valid_o (beat_valid_o),
    .beat_ready_i (beat_ready_i),
    .beat_addr_o  (beat_addr_o),
    .beat_reg_o   (beat_reg_o),
    .done_o       (done_o),
    .wb_valid_o   (wb_valid_o)
);

// File: tb/test_blk_xfer_seq.sv
// Self-checking bench: a vector table of requests walked by one loop, then
// directed reset and empty-mask cases.
module test_blk_xfer_seq;

    typedef struct packed {
        logic [31:0] base;
        logic [15:0] list;
        logic [1:0]  mode;
        logic        wb;
        logic        load;
        logic        stall;
        logic [31:0] first;
        logic [31:0] fin;
    } vec_t;

    localparam int NVEC = 8;
    localparam vec_t VEC [NVEC] = '{
        '{32'h0000_1000, 16'h000F, 2'd0, 1'b1, 1'b1, 1'b0, 32'h0000_1000, 32'h0000_1010},
        '{32'h0000_1000, 16'h8001, 2'd1, 1'b0, 1'b0, 1'b1, 32'h0000_1004, 32'h0000_1008},
        '{32'h0000_2000, 16'h00F0, 2'd2, 1'b1, 1'b0, 1'b1, 32'h0000_1FF4, 32'h0000_1FF0},
        '{32'h0000_2000, 16'h0C03, 2'd3, 1'b1, 1'b1, 1'b0, 32'h0000_1FF0, 32'h0000_1FF0},
        '{32'h0000_0003, 16'hFFFF, 2'd0, 1'b1, 1'b0, 1'b1, 32'h0000_0000, 32'h0000_0040},
        '{32'h0000_0010, 16'h0001, 2'd3, 1'b1, 1'b1, 1'b1, 32'h0000_000C, 32'h0000_000C},
        '{32'h0000_0000, 16'h0002, 2'd2, 1'b1, 1'b0, 1'b0, 32'h0000_0000, 32'hFFFF_FFFC},
        '{32'h8000_0006, 16'h4100, 2'd1, 1'b0, 1'b1, 1'b1, 32'h8000_0008, 32'h8000_000C}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [31:0] base_i = '0;
    logic [15:0] reg_list_i = '0;
    logic [1:0]  mode_i = '0;
    logic        wb_en_i = 1'b0;
    logic        dir_load_i = 1'b0;
    logic        beat_ready_i = 1'b0;
    logic        busy_o, beat_valid_o, beat_load_o, done_o, wb_valid_o;
    logic [31:0] beat_addr_o, wb_addr_o;
    logic [3:0]  beat_reg_o;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    blk_xfer_seq i_blk_xfer_seq (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .base_i(base_i),
        .reg_list_i(reg_list_i), .mode_i(mode_i), .wb_en_i(wb_en_i),
        .dir_load_i(dir_load_i), .busy_o(busy_o), .beat_valid_o(beat_valid_o),
        .beat_ready_i(beat_ready_i), .beat_addr_o(beat_addr_o),
        .beat_reg_o(beat_reg_o), .beat_load_o(beat_load_o), .done_o(done_o),
        .wb_valid_o(wb_valid_o), .wb_addr_o(wb_addr_o)
    );

    always #5 clk = ~clk;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Runs one request; checks beats, completion and writeback.
    task automatic run_xfer(input vec_t v);
        int beats = 0;
        int n = 0;
        int nxt = 0;
        int last_hs = -1;
        int cyc = 0;
        bit got_done = 1'b0;
        for (int i = 0; i < 16; i++) n += int'(v.list[i]);
        @(negedge clk);
        start_i = 1'b1; base_i = v.base; reg_list_i = v.list;
        mode_i = v.mode; wb_en_i = v.wb; dir_load_i = v.load;
        @(negedge clk);
        // R1: a second start while busy, carrying a different request
        chk(busy_o == 1'b1, "R1 busy after accept", 32'(busy_o), 32'd1);
        base_i = 32'hDEAD_0000; reg_list_i = 16'hFFFF; mode_i = 2'd3;
        wb_en_i = ~v.wb; dir_load_i = ~v.load;
        while (!got_done && cyc < 200) begin
            if (cyc == 1) start_i = 1'b0;
            beat_ready_i = 1'b0;
            if (done_o) begin
                got_done = 1'b1;
                chk(beats == n, "R2 beat count", 32'(beats), 32'(n));
                if (n == 0)
                    chk(cyc == 0, "R9 empty done timing", 32'(cyc), 32'd0);
                else
                    chk(cyc == last_hs + 1, "R7 done after last beat", 32'(cyc), 32'(last_hs + 1));
                chk(wb_valid_o == v.wb, "R8 writeback flag", 32'(wb_valid_o), 32'(v.wb));
                chk(wb_addr_o == v.fin, "R8 writeback address", wb_addr_o, v.fin);
            end else if (beat_valid_o) begin
                if (!v.stall || (cyc % 3 == 2)) begin
                    beat_ready_i = 1'b1;
                    while (nxt < 16 && !v.list[nxt]) nxt++;
                    chk(beat_reg_o == 4'(nxt), "R2 register order", 32'(beat_reg_o), 32'(nxt));
                    chk(beat_addr_o == v.first + 32'(4 * beats), "R3/R4 beat address",
                        beat_addr_o, v.first + 32'(4 * beats));
                    chk(beat_addr_o[1:0] == 2'b00, "R5 alignment", 32'(beat_addr_o[1:0]), 32'd0);
                    chk(beat_load_o == v.load, "R10 direction", 32'(beat_load_o), 32'(v.load));
                    nxt++;
                    beats++;
                    last_hs = cyc;
                end
            end
            if (!got_done) begin
                @(negedge clk);
                cyc++;
            end
        end
        start_i = 1'b0;
        beat_ready_i = 1'b0;
        chk(got_done, "R7 done seen", 32'(got_done), 32'd1);
        @(negedge clk);
        chk(done_o == 1'b0, "R7 done single cycle", 32'(done_o), 32'd0);
        chk(busy_o == 1'b0, "R1 idle after done", 32'(busy_o), 32'd0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        // Reset state
        chk(busy_o == 1'b0, "R1 reset busy", 32'(busy_o), 32'd0);
        chk(beat_valid_o == 1'b0, "R2 reset valid", 32'(beat_valid_o), 32'd0);
        chk(done_o == 1'b0, "R7 reset done", 32'(done_o), 32'd0);
        rst_n = 1'b1;
        for (int k = 0; k < NVEC; k++) run_xfer(VEC[k]);
        // R9: empty mask, step-down mode, unaligned base
        run_xfer('{32'h0000_3007, 16'h0000, 2'd3, 1'b1, 1'b0, 1'b0, 32'h0, 32'h0000_3004});
        // R9: empty mask, step-up-first mode, no writeback
        run_xfer('{32'h0000_5000, 16'h0000, 2'd1, 1'b0, 1'b1, 1'b1, 32'h0, 32'h0000_5000});
        // R3: single register at the top index, step-up-first
        run_xfer('{32'h0000_0100, 16'h8000, 2'd1, 1'b1, 1'b1, 1'b1, 32'h0000_0104, 32'h0000_0104});
        finished = 1'b1;
    end

    initial begin
        for (int t = 0; t < 20000; t++) begin
            @(negedge clk);
            if (finished) break;
        end
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=finished");
        end
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule